// File: doc/BRIEF.md
# Peripheral Register Unit with UART Interrupt Arbitration

This block connects a small processor to its on-board peripherals through an 8-bit register address space. The processor side supplies an address, write data and separate read and write strobes. Reads are answered combinationally from the addressed register, so the data is ready to be captured at the next clock edge. Writes take effect on the clock edge. Behind the address space sit a bank of switch inputs, a seven-segment output, an LED that toggles on every display write, a view of a serial port's status and fixed format settings, and two interrupt enables for that serial port.

The unit also turns the serial port's receive and transmit conditions into a registered 6-bit interrupt vector. Bit 5 of the vector means an interrupt is pending. Receive has priority over transmit. Once a vector is pending it keeps its value while any enabled source is still active. The data-register strobes for the serial port are the processor's strobes, qualified by an address match. The serial port itself is outside this block.

Top module: `periph_regs`

## Requirements
- R1: A read of any address not listed in R2, R4, R5, R6 or R7 returns 0xAA.
- R2: Address 0x36 reads back the 8-bit switch input unchanged.
- R3: A write strobe at address 0x38 loads write-data bits 6:0 into the seven-segment output and inverts the LED output at that clock edge.
- R4: A write strobe at address 0x43 sets the receive interrupt enable from data bit 0 and the transmit interrupt enable from data bit 1. Address 0x2A reads {rx_en, tx_en, tx_en, 1, 1, 0, 0, 0}, with bit 7 first.
- R5: Address 0x2B reads {rx_ready, ~tx_busy, ~tx_busy, 5'b00000}, with bit 7 first.
- R6: Address 0x40 reads the constant 0x8E.
- R7: Address 0x2C reads the received byte. uart_wr equals the write strobe and uart_rd equals the read strobe when the address is 0x2C, and both are 0 at any other address.
- R8: When no vector is pending (bit 5 is 0), an enabled and ready receiver loads 6'b101011 at the next edge. Otherwise an enabled transmitter that is not busy loads 6'b101100.
- R9: While bit 5 is 1 and at least one enabled source is active, the vector holds its value.
- R10: When neither enabled source is active, the vector becomes 0 at the next edge.
- R11: A clear sampled at an edge sets the vector, both enables, the segment output and the LED to 0.
- R12: Writes to any address other than 0x38 and 0x43 leave the enables, the segment output and the LED unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the processor |
| clr | input | 1 | Synchronous clear, active high |
| reg_addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| rd_data | output | 8 | Read data, combinational on the address |
| switches | input | 8 | Switch inputs |
| seg_out | output | 7 | Seven-segment drive |
| led_out | output | 1 | LED, toggles on each display write |
| rx_ready | input | 1 | Serial receiver has a byte |
| rx_byte | input | 8 | Received byte |
| tx_busy | input | 1 | Serial transmitter is busy |
| uart_wr | output | 1 | Write strobe for the serial data register |
| uart_rd | output | 1 | Read strobe for the serial data register |
| irq_vec | output | 6 | Interrupt vector, bit 5 means pending |

## Verification
Two things can happen in the same cycle: a write to the enable register, and interrupt arbitration that still uses the old enables. Both serial sources can also be active together while a vector is already pending. The bench causes both overlaps. It writes 0x43 while rx_ready and a free transmitter are present, and it toggles the source flags slowly at random so that pending vectors meet changing sources. Each edge is judged against a bench model that arbitrates with the enable values from before the write.

// File: rtl/periph_regs.sv
module periph_regs #(
  parameter logic [7:0] A_CTRL   = 8'h2A,
  parameter logic [7:0] A_STAT   = 8'h2B,
  parameter logic [7:0] A_DATA   = 8'h2C,
  parameter logic [7:0] A_SW     = 8'h36,
  parameter logic [7:0] A_SEG    = 8'h38,
  parameter logic [7:0] A_FMT    = 8'h40,
  parameter logic [7:0] A_IEN    = 8'h43,
  parameter logic [7:0] FMT_VAL  = 8'h8E,
  parameter logic [7:0] FILL_VAL = 8'hAA,
  parameter logic [5:0] VEC_RX   = 6'b101011,
  parameter logic [5:0] VEC_TX   = 6'b101100
) (
  input  logic       clk,
  input  logic       clr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_stb,
  input  logic       wr_stb,
  output logic [7:0] rd_data,
  input  logic [7:0] switches,
  output logic [6:0] seg_out,
  output logic       led_out,
  input  logic       rx_ready,
  input  logic [7:0] rx_byte,
  input  logic       tx_busy,
  output logic       uart_wr,
  output logic       uart_rd,
  output logic [5:0] irq_vec
);

  logic rx_en, tx_en;
  logic rx_hit, tx_hit;

  assign rx_hit = rx_en & rx_ready;
  assign tx_hit = tx_en & ~tx_busy;

  always_comb begin
    case (reg_addr)
      A_CTRL:  rd_data = {rx_en, tx_en, tx_en, 2'b11, 3'b000};
      A_STAT:  rd_data = {rx_ready, ~tx_busy, ~tx_busy, 5'b00000};
      A_DATA:  rd_data = rx_byte;
      A_SW:    rd_data = switches;
      A_FMT:   rd_data = FMT_VAL;
      default: rd_data = FILL_VAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      rx_en   <= 1'b0;
      tx_en   <= 1'b0;
      seg_out <= '0;
      led_out <= 1'b0;
    end else if (wr_stb) begin
      if (reg_addr == A_SEG) begin
        seg_out <= wr_data[6:0];
        led_out <= ~led_out;
      end
      if (reg_addr == A_IEN) begin
        rx_en <= wr_data[0];
        tx_en <= wr_data[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr)
      irq_vec <= '0;
    else if (rx_hit) begin
      if (!irq_vec[5]) irq_vec <= VEC_RX;
    end else if (tx_hit) begin
      if (!irq_vec[5]) irq_vec <= VEC_TX;
    end else
      irq_vec <= '0;
  end

  assign uart_wr = wr_stb & (reg_addr == A_DATA);
  assign uart_rd = rd_stb & (reg_addr == A_DATA);

endmodule

// File: rtl/periph_regs_chk.sv
module periph_regs_chk (
  input logic       clk,
  input logic       clr,
  input logic [7:0] reg_addr,
  input logic [7:0] wr_data,
  input logic       wr_stb,
  input logic [6:0] seg_out,
  input logic       led_out,
  input logic       rx_ready,
  input logic       tx_busy,
  input logic       rx_en,
  input logic       tx_en,
  input logic [5:0] irq_vec
);

  AST_CLEAR_STATE: assert property (@(posedge clk) clr |=> (irq_vec == 6'd0 && seg_out == 7'd0 && !led_out && !rx_en && !tx_en)); // R11

  AST_SEG_WRITE: assert property (@(posedge clk) disable iff (clr)
    (wr_stb && reg_addr == 8'h38) |=> (seg_out == $past(wr_data[6:0]) && led_out != $past(led_out))); // R3

  AST_RX_FIRST: assert property (@(posedge clk) disable iff (clr)
    (!irq_vec[5] && rx_en && rx_ready) |=> (irq_vec == 6'b101011)); // R8

  AST_PENDING_HOLD: assert property (@(posedge clk) disable iff (clr)
    (irq_vec[5] && ((rx_en && rx_ready) || (tx_en && !tx_busy))) |=> $stable(irq_vec)); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (clr)
    (!(rx_en && rx_ready) && !(tx_en && !tx_busy)) |=> (irq_vec == 6'd0)); // R10

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (clr)
    (irq_vec == 6'd0 || irq_vec == 6'b101011 || irq_vec == 6'b101100)); // R8

endmodule

bind periph_regs periph_regs_chk u_chk (
  .clk(clk), .clr(clr), .reg_addr(reg_addr), .wr_data(wr_data), .wr_stb(wr_stb),
  .seg_out(seg_out), .led_out(led_out), .rx_ready(rx_ready), .tx_busy(tx_busy),
  .rx_en(rx_en), .tx_en(tx_en), .irq_vec(irq_vec)
);

// File: tb/test_periph_regs.sv
`timescale 1ns/1ps
module test_periph_regs;
  logic       clk = 1'b0;
  logic       clr, rd_stb, wr_stb, rx_ready, tx_busy;
  logic [7:0] reg_addr, wr_data, switches, rx_byte;
  logic [7:0] rd_data;
  logic [6:0] seg_out;
  logic       led_out, uart_wr, uart_rd;
  logic [5:0] irq_vec;

  int n_chk = 0, n_bad = 0;
  logic       m_rxen, m_txen, m_led;
  logic [6:0] m_seg;
  logic [5:0] m_vec;

  always #2.5 clk = ~clk;

  periph_regs i_periph_regs (
    .clk(clk), .clr(clr), .reg_addr(reg_addr), .wr_data(wr_data), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .rd_data(rd_data), .switches(switches), .seg_out(seg_out),
    .led_out(led_out), .rx_ready(rx_ready), .rx_byte(rx_byte), .tx_busy(tx_busy),
    .uart_wr(uart_wr), .uart_rd(uart_rd), .irq_vec(irq_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h2A:   return {m_rxen, m_txen, m_txen, 2'b11, 3'b000};
      8'h2B:   return {rx_ready, ~tx_busy, ~tx_busy, 5'b0};
      8'h2C:   return rx_byte;
      8'h36:   return switches;
      8'h40:   return 8'h8E;
      default: return 8'hAA;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h2A: return "R4";
      8'h2B: return "R5";
      8'h2C: return "R7";
      8'h36: return "R2";
      8'h40: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic cycle(input logic c, input logic [7:0] a, input logic [7:0] d,
                       input logic rs, input logic ws, input logic rdy, input logic bsy);
    @(negedge clk);
    clr = c; reg_addr = a; wr_data = d; rd_stb = rs; wr_stb = ws;
    rx_ready = rdy; tx_busy = bsy;
    switches = 8'($urandom); rx_byte = 8'($urandom);
    #1;
    chk(req_of(a), {24'd0, rd_data}, {24'd0, exp_rd(a)});
    chk("R7 wr", {31'd0, uart_wr}, {31'd0, ws && a == 8'h2C});
    chk("R7 rd", {31'd0, uart_rd}, {31'd0, rs && a == 8'h2C});
    chk("R3/R11/R12 seg", {25'd0, seg_out}, {25'd0, m_seg});
    chk("R3/R11/R12 led", {31'd0, led_out}, {31'd0, m_led});
    chk("R8/R9/R10/R11 vec", {26'd0, irq_vec}, {26'd0, m_vec});
    if (c) begin
      m_rxen = 0; m_txen = 0; m_seg = 0; m_led = 0; m_vec = 0;
    end else begin
      if (m_rxen && rdy) begin
        if (!m_vec[5]) m_vec = 6'b101011;
      end else if (m_txen && !bsy) begin
        if (!m_vec[5]) m_vec = 6'b101100;
      end else m_vec = 6'd0;
      if (ws && a == 8'h38) begin m_seg = d[6:0]; m_led = ~m_led; end
      if (ws && a == 8'h43) begin m_rxen = d[0]; m_txen = d[1]; end
    end
  endtask

  initial begin
    #(200000 * 5.0);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic rdy, bsy;
    logic [7:0] addr_set [8];
    void'($urandom(32'd20240611));
    addr_set = '{8'h2A, 8'h2B, 8'h2C, 8'h36, 8'h38, 8'h40, 8'h43, 8'h00};
    m_rxen = 0; m_txen = 0; m_seg = 0; m_led = 0; m_vec = 0;
    clr = 1; reg_addr = 0; wr_data = 0; rd_stb = 0; wr_stb = 0;
    rx_ready = 0; tx_busy = 1; switches = 0; rx_byte = 0;
    repeat (3) @(posedge clk);
    // R11 reset state, then directed cases
    cycle(1, 8'h2A, 8'h00, 1, 0, 0, 1);
    cycle(0, 8'h40, 8'h00, 1, 0, 0, 1);                 // R6
    cycle(0, 8'h36, 8'h00, 1, 0, 0, 1);                 // R2
    cycle(0, 8'h77, 8'h00, 1, 0, 0, 1);                 // R1
    cycle(0, 8'h38, 8'hFF, 0, 1, 0, 1);                 // R3
    cycle(0, 8'h38, 8'h15, 0, 1, 0, 1);                 // R3 second toggle
    cycle(0, 8'h43, 8'h03, 0, 1, 1, 0);                 // R4 write while both sources active
    cycle(0, 8'h2A, 8'h00, 1, 0, 1, 0);                 // R8 rx wins
    cycle(0, 8'h2B, 8'h00, 1, 0, 0, 0);                 // R9 hold on tx
    cycle(0, 8'h2C, 8'h00, 1, 1, 0, 1);                 // R10 idle, R7 strobes
    cycle(0, 8'h2A, 8'h03, 0, 1, 0, 0);                 // R12 write elsewhere
    cycle(0, 8'h2A, 8'h00, 1, 0, 0, 0);
    cycle(1, 8'h2A, 8'h00, 1, 0, 1, 0);                 // R11 clear mid-run
    cycle(0, 8'h2A, 8'h00, 1, 0, 1, 0);
    rdy = 0; bsy = 1;
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      int k;
      k = int'($urandom % 9);
      a = (k == 8) ? 8'($urandom) : addr_set[k];
      if ($urandom % 4 == 0) rdy = ~rdy;
      if ($urandom % 4 == 0) bsy = ~bsy;
      cycle(($urandom % 200) == 0, a, 8'($urandom), 1'($urandom), ($urandom % 3) == 0, rdy, bsy);
    end
    cycle(0, 8'h00, 8'h00, 0, 0, rdy, bsy);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule